// File: doc/BRIEF.md
# Dual-Tap Line Reassembler with Dark Clamp and Gain Trim

This block rebuilds one linear image line from a sensor that reads its pixels out through two parallel taps. Samples arrive as pairs, one sample per tap in the same cycle. The odd tap carries pixels 1, 3, 5 and so on, and the even tap carries pixels 2, 4, 6 and so on. Each tap starts a line with a fixed prefix of non-image samples: a run of isolation samples, then a run of light-shielded samples, then a short run of isolation samples. After that come the active samples. Any overclock samples that follow the active run are dropped.

For each tap, the block averages that tap's shielded samples into a dark level. It subtracts the dark level from every active sample of the same tap, then scales the result by a per-tap gain word to trim the mismatch between the two output amplifiers. The corrected pair goes into a line buffer at two neighbouring addresses, so the buffer holds the line in spatial order. A valid/ready stream reads the line back from pixel 1 and flags the final pixel. The stream can start as soon as the first active pair has been written. The consumer must drain a line before the next line starts, because a new line start moves the reader back to pixel 1.

Top module: `tap_line_merge`

## Requirements
- R1: After reset, `out_valid` is low and stays low until an active pair of a line has been accepted.
- R2: A sample pair is accepted on a cycle with `in_valid` high, and the pair that also has `in_line_start` high is sample 0 of a line. Active pair k (from 0) becomes output pixels 2k+1 (odd tap) and 2k+2 (even tap), and these are streamed in increasing pixel order.
- R3: Each tap's line starts with LEAD_ISO isolation samples, then SHIELD_N shielded samples, then POST_ISO isolation samples (defaults 5, 16 and 2). Isolation samples affect neither the dark level nor the output, and no output is produced before the first active pair.
- R4: Each tap's dark level is the sum of its SHIELD_N shielded samples of the current line, shifted right by log2(SHIELD_N). It is rebuilt on every line.
- R5: An active sample at or below its tap's dark level gives a dark-corrected value of 0. Otherwise the dark-corrected value is the sample minus the dark level.
- R6: The dark-corrected value is multiplied by the tap's gain word, which is unsigned with GAIN_FRAC fractional bits (default 2.10). The product is shifted right by GAIN_FRAC and clamped to 2^SAMPLE_W-1.
- R7: Samples after the ACTIVE_PER_TAP active samples of a tap are discarded until the next line start, as are all samples accepted before the first line start.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `out_last` is high exactly with pixel 2*ACTIVE_PER_TAP. After that pixel is taken, `out_valid` stays low until the next line writes data.
- R9: A pixel can be presented on the cycle after its pair is accepted. A line start moves the reader back to pixel 1.
- R10: Cycles with `in_valid` low do not advance the sample position, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_line_start | input | 1 | Marks sample 0 of a line (qualified by in_valid) |
| in_odd | input | SAMPLE_W | Odd-pixel tap sample |
| in_even | input | SAMPLE_W | Even-pixel tap sample |
| gain_odd | input | GAIN_W | Odd-tap gain, GAIN_FRAC fractional bits |
| gain_even | input | GAIN_W | Even-tap gain, GAIN_FRAC fractional bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_data | output | SAMPLE_W | Corrected pixel |
| out_last | output | 1 | Final pixel of the line |

## Verification
The bench builds the block with 8-bit samples, 8 active samples per tap (a 16-pixel line), a prefix of 2 isolation, 4 shielded and 1 isolation sample, and a 2.10 gain. With a line this short, every pixel of every line is compared against an arithmetic model. Four lines cover unity, fractional, above-unity, maximum and zero gains, dark levels at both extremes, clamping at zero and at full scale, input gaps carrying junk data, overclock runs from zero to 23, and consumer stalls.

// File: rtl/lr_pkg.sv
`timescale 1ns/100ps
package lr_pkg;

   // Classification of the sample currently presented on both taps.
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,   // no sample, overclock, or before the first line
      PH_ISO    = 2'd1,   // isolation sample, never used
      PH_SHIELD = 2'd2,   // light-shielded sample, feeds the dark level
      PH_ACTIVE = 2'd3    // image sample
   } tap_phase_e;

endpackage

// File: rtl/lr_phase_seq.sv
`timescale 1ns/100ps
module lr_phase_seq
   import lr_pkg::*;
#(
   parameter int LEAD_ISO = 5,
   parameter int SHIELD_N = 16,
   parameter int POST_ISO = 2,
   parameter int ACTIVE_N = 2048,
   localparam int AW      = $clog2(ACTIVE_N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic          smp_first,
   output tap_phase_e    phase,
   output logic [AW-1:0] act_idx
);

   localparam int TOTAL = LEAD_ISO + SHIELD_N + POST_ISO + ACTIVE_N;
   localparam int IW    = $clog2(TOTAL + 1);
   localparam logic [IW-1:0] SH_LO  = IW'(LEAD_ISO);
   localparam logic [IW-1:0] SH_HI  = IW'(LEAD_ISO + SHIELD_N);
   localparam logic [IW-1:0] ACT_LO = IW'(LEAD_ISO + SHIELD_N + POST_ISO);
   localparam logic [IW-1:0] ENDV   = IW'(TOTAL);

   if (LEAD_ISO < 1) begin : g_bad_lead
      $error("lr_phase_seq: LEAD_ISO must be at least 1");
   end
   if (ACTIVE_N < 2) begin : g_bad_active
      $error("lr_phase_seq: ACTIVE_N must be at least 2");
   end

   logic [IW-1:0] idx_q;
   logic [IW-1:0] cur;
   logic [IW-1:0] rel;

   // Position of the sample on the inputs; a line start forces position 0.
   assign cur = smp_first ? '0 : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= ENDV;
      end else if (smp_valid) begin
         if (cur != ENDV) idx_q <= cur + 1'b1;
         else             idx_q <= ENDV;
      end
   end

   always_comb begin
      if (!smp_valid)        phase = PH_IDLE;
      else if (cur < SH_LO)  phase = PH_ISO;
      else if (cur < SH_HI)  phase = PH_SHIELD;
      else if (cur < ACT_LO) phase = PH_ISO;
      else if (cur < ENDV)   phase = PH_ACTIVE;
      else                   phase = PH_IDLE;
   end

   assign rel     = cur - ACT_LO;
   assign act_idx = rel[AW-1:0];

   a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= ENDV);

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(idx_q));

endmodule

// File: rtl/lr_dark_est.sv
`timescale 1ns/100ps
module lr_dark_est #(
   parameter int SAMPLE_W = 12,
   parameter int SHIELD_N = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                shield_en,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] dark
);

   localparam int SH_SHIFT = $clog2(SHIELD_N);
   localparam int ACC_W    = SAMPLE_W + SH_SHIFT;

   if ((1 << SH_SHIFT) != SHIELD_N) begin : g_bad_shield
      $error("lr_dark_est: SHIELD_N must be a power of two");
   end

   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q <= '0;
      else if (restart)   acc_q <= '0;
      else if (shield_en) acc_q <= acc_q + ACC_W'(sample);
   end

   // Mean by shift: drop the low log2(SHIELD_N) bits of the sum.
   assign dark = acc_q[ACC_W-1:SH_SHIFT];

   a_r3_iso_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!shield_en && !restart) |=> $stable(acc_q));

endmodule

// File: rtl/lr_tap_fix.sv
`timescale 1ns/100ps
module lr_tap_fix #(
   parameter int SAMPLE_W  = 12,
   parameter int GAIN_W    = 12,
   parameter int GAIN_FRAC = 10
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] dark,
   input  logic [GAIN_W-1:0]   gain,
   output logic [SAMPLE_W-1:0] fixed
);

   localparam int PW = SAMPLE_W + GAIN_W;
   localparam logic [GAIN_W-1:0]   UNITY  = GAIN_W'(1) << GAIN_FRAC;
   localparam logic [SAMPLE_W-1:0] FULL   = '1;

   if (GAIN_FRAC >= GAIN_W) begin : g_bad_gain
      $error("lr_tap_fix: GAIN_W must exceed GAIN_FRAC");
   end

   logic [SAMPLE_W-1:0] diff;
   logic [PW-1:0]       prod;
   logic [PW-1:0]       scaled;

   assign diff   = (sample > dark) ? (sample - dark) : '0;
   assign prod   = PW'(diff) * PW'(gain);
   assign scaled = prod >> GAIN_FRAC;

   always_comb begin
      if (scaled[PW-1:SAMPLE_W] != '0) fixed = FULL;
      else                             fixed = scaled[SAMPLE_W-1:0];
   end

   always_comb begin
      if (sample <= dark) begin
         a_r5_floor: assert (fixed == '0);
      end
      if (gain <= UNITY) begin
         a_r6_unity_cap: assert (fixed <= sample);
      end
   end

endmodule

// File: rtl/lr_line_buf.sv
`timescale 1ns/100ps
module lr_line_buf #(
   parameter int SAMPLE_W    = 12,
   parameter int DEPTH_PAIRS = 2048,
   localparam int PAW        = $clog2(DEPTH_PAIRS),
   localparam int XW         = PAW + 1
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [PAW-1:0]      wr_pair,
   input  logic [SAMPLE_W-1:0] wr_lo,
   input  logic [SAMPLE_W-1:0] wr_hi,
   input  logic [XW-1:0]       rd_addr,
   output logic [SAMPLE_W-1:0] rd_data
);

   localparam int DEPTH = 2 * DEPTH_PAIRS;

   logic [SAMPLE_W-1:0] mem [DEPTH];

   // Pair k lands at addresses 2k (odd tap) and 2k+1 (even tap).
   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[{wr_pair, 1'b0}] <= wr_lo;
         mem[{wr_pair, 1'b1}] <= wr_hi;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tap_line_merge.sv
`timescale 1ns/100ps
module tap_line_merge
   import lr_pkg::*;
#(
   parameter int SAMPLE_W       = 12,
   parameter int ACTIVE_PER_TAP = 2048,
   parameter int LEAD_ISO       = 5,
   parameter int SHIELD_N       = 16,
   parameter int POST_ISO       = 2,
   parameter int GAIN_W         = 12,
   parameter int GAIN_FRAC      = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_line_start,
   input  logic [SAMPLE_W-1:0] in_odd,
   input  logic [SAMPLE_W-1:0] in_even,
   input  logic [GAIN_W-1:0]   gain_odd,
   input  logic [GAIN_W-1:0]   gain_even,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_data,
   output logic                out_last
);

   localparam int NPIX = 2 * ACTIVE_PER_TAP;
   localparam int AW   = $clog2(ACTIVE_PER_TAP);
   localparam int XW   = AW + 1;
   localparam int CW   = $clog2(NPIX + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(NPIX);
   localparam logic [XW-1:0] LAST_PIX = XW'(NPIX - 1);

   logic                line_go;
   tap_phase_e          phase;
   logic [AW-1:0]       pair_idx;
   logic                wr_en;
   logic [SAMPLE_W-1:0] tap_smp [2];
   logic [GAIN_W-1:0]   tap_gain [2];
   logic [SAMPLE_W-1:0] tap_dark [2];
   logic [SAMPLE_W-1:0] tap_fix [2];
   logic [CW-1:0]       wr_cnt_q;
   logic [XW-1:0]       rd_q;
   logic                rd_done_q;
   logic                take;

   assign line_go     = in_valid & in_line_start;
   assign tap_smp[0]  = in_odd;
   assign tap_smp[1]  = in_even;
   assign tap_gain[0] = gain_odd;
   assign tap_gain[1] = gain_even;

   lr_phase_seq #(
      .LEAD_ISO (LEAD_ISO),
      .SHIELD_N (SHIELD_N),
      .POST_ISO (POST_ISO),
      .ACTIVE_N (ACTIVE_PER_TAP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (in_valid),
      .smp_first (line_go),
      .phase     (phase),
      .act_idx   (pair_idx)
   );

   for (genvar t = 0; t < 2; t++) begin : g_tap
      lr_dark_est #(
         .SAMPLE_W (SAMPLE_W),
         .SHIELD_N (SHIELD_N)
      ) u_dark (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart   (line_go),
         .shield_en (phase == PH_SHIELD),
         .sample    (tap_smp[t]),
         .dark      (tap_dark[t])
      );

      lr_tap_fix #(
         .SAMPLE_W  (SAMPLE_W),
         .GAIN_W    (GAIN_W),
         .GAIN_FRAC (GAIN_FRAC)
      ) u_fix (
         .sample (tap_smp[t]),
         .dark   (tap_dark[t]),
         .gain   (tap_gain[t]),
         .fixed  (tap_fix[t])
      );
   end

   assign wr_en = (phase == PH_ACTIVE);

   lr_line_buf #(
      .SAMPLE_W    (SAMPLE_W),
      .DEPTH_PAIRS (ACTIVE_PER_TAP)
   ) u_buf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_pair (pair_idx),
      .wr_lo   (tap_fix[0]),
      .wr_hi   (tap_fix[1]),
      .rd_addr (rd_q),
      .rd_data (out_data)
   );

   // Count of pixels of the current line held in the buffer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_cnt_q <= '0;
      else if (line_go) wr_cnt_q <= wr_en ? CW'(2) : '0;
      else if (wr_en)   wr_cnt_q <= wr_cnt_q + CW'(2);
   end

   assign out_valid = !rd_done_q && (CW'(rd_q) < wr_cnt_q);
   assign out_last  = (rd_q == LAST_PIX);
   assign take      = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= '0;
         rd_done_q <= 1'b0;
      end else if (line_go) begin
         rd_q      <= '0;
         rd_done_q <= 1'b0;
      end else if (take) begin
         if (out_last) begin
            rd_q      <= '0;
            rd_done_q <= 1'b1;
         end else begin
            rd_q <= rd_q + 1'b1;
         end
      end
   end

   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !line_go) |=> (out_valid && $stable(out_data)));

   a_r8_line_drained: assert property (@(posedge clk) disable iff (!rst_n)
      (take && out_last && !line_go) |=> !out_valid);

   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_q <= FULL_CNT);

   a_r3_prefix_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      line_go |=> (wr_cnt_q == '0));

endmodule

// File: tb/tap_line_merge_test.sv
`timescale 1ns/100ps
module tap_line_merge_test;

   localparam int SW   = 8;
   localparam int APT  = 8;
   localparam int LEAD = 2;
   localparam int SH   = 4;
   localparam int POST = 1;
   localparam int GW   = 12;
   localparam int GF   = 10;
   localparam int NPIX = 2 * APT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_line_start = 1'b0;
   logic [SW-1:0] in_odd = '0;
   logic [SW-1:0] in_even = '0;
   logic [GW-1:0] gain_odd = '0;
   logic [GW-1:0] gain_even = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [SW-1:0] out_data;
   logic          out_last;

   always #2.5 clk = ~clk;

   tap_line_merge #(
      .SAMPLE_W(SW), .ACTIVE_PER_TAP(APT), .LEAD_ISO(LEAD), .SHIELD_N(SH),
      .POST_ISO(POST), .GAIN_W(GW), .GAIN_FRAC(GF)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
      .in_odd(in_odd), .in_even(in_even), .gain_odd(gain_odd), .gain_even(gain_even),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int act_v [2][APT];
   int shd_v [2][SH];
   int gain_v [2];

   task automatic check(bit ok, string req, int actual, int expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   function automatic int expect_px(int p);
      int t = p % 2;
      int k = p / 2;
      int s = 0;
      int dark, d, v;
      for (int j = 0; j < SH; j++) s += shd_v[t][j];
      dark = s / SH;
      d = (act_v[t][k] > dark) ? act_v[t][k] - dark : 0;
      v = (d * gain_v[t]) / (1 << GF);
      if (v > 255) v = 255;
      return v;
   endfunction

   task automatic put(bit ls, int a, int b);
      in_valid = 1'b1;
      in_line_start = ls;
      in_odd = SW'(a);
      in_even = SW'(b);
      @(negedge clk);
      in_valid = 1'b0;
      in_line_start = 1'b0;
   endtask

   task automatic gap(int n);
      in_valid = 1'b0;
      in_line_start = 1'b1;   // junk while invalid (R10)
      in_odd = 8'hEE;
      in_even = 8'h11;
      repeat (n) @(negedge clk);
      in_line_start = 1'b0;
   endtask

   task automatic send_line(int over, int gap_every, bit probe);
      gain_odd = GW'(gain_v[0]);
      gain_even = GW'(gain_v[1]);
      for (int i = 0; i < LEAD; i++) put(i == 0, 255, 254 - i);
      for (int j = 0; j < SH; j++) begin
         put(1'b0, shd_v[0][j], shd_v[1][j]);
         if (gap_every != 0) gap(1);
      end
      for (int i = 0; i < POST; i++) put(1'b0, 240, 241);
      if (probe) check(out_valid == 1'b0, "R3 no output from prefix", out_valid, 0);
      for (int k = 0; k < APT; k++) begin
         put(1'b0, act_v[0][k], act_v[1][k]);
         if (probe && k == 0) begin
            check(out_valid == 1'b1, "R9 pixel ready after first pair", out_valid, 1);
            check(int'(out_data) == expect_px(0), "R2 pixel 1 from odd tap", out_data, expect_px(0));
         end
         if (gap_every != 0 && (k % gap_every) == 0) gap(2);
      end
      for (int o = 0; o < over; o++) put(1'b0, 170, 85);
      gap(1);
   endtask

   task automatic drain(int stall_mod, string tag);
      int got = 0;
      int guard = 0;
      while (got < NPIX && guard < 1000) begin
         out_ready = (stall_mod == 0) || ((guard % stall_mod) != 0);
         if (out_valid && out_ready) begin
            check(int'(out_data) == expect_px(got), {tag, " R5 R6 pixel value"}, out_data, expect_px(got));
            check(out_last == (got == NPIX - 1), {tag, " R8 last flag"}, out_last, got == NPIX - 1);
            got++;
         end
         @(negedge clk);
         guard++;
      end
      out_ready = 1'b0;
      check(got == NPIX, {tag, " R2 pixel count"}, got, NPIX);
      check(out_valid == 1'b0, {tag, " R8 idle after last"}, out_valid, 0);
   endtask

   task automatic setup_line(int n);
      for (int t = 0; t < 2; t++)
         for (int k = 0; k < APT; k++)
            case (n)
               1: act_v[t][k] = (k * 37 + t * 50 + 5) % 256;
               2: act_v[t][k] = (t == 0) ? k * 30 + 7 : 190 + k * 8;
               3: act_v[t][k] = (t == 0) ? 100 + k * 20 : 250;
               default: act_v[t][k] = (t == 0) ? k * 30 : 255 - k;
            endcase
      for (int j = 0; j < SH; j++)
         case (n)
            1: begin shd_v[0][j] = 10 + j; shd_v[1][j] = (j == 3) ? 24 : 20; end
            2: begin shd_v[0][j] = 0; shd_v[1][j] = 200 + j; end
            3: begin shd_v[0][j] = j * 2; shd_v[1][j] = j * 2; end
            default: begin shd_v[0][j] = 255; shd_v[1][j] = 5; end
         endcase
      case (n)
         1: begin gain_v[0] = 1024; gain_v[1] = 1024; act_v[0][0] = 3; act_v[1][3] = 21; end
         2: begin gain_v[0] = 512;  gain_v[1] = 1536; end
         3: begin gain_v[0] = 4095; gain_v[1] = 0;    end
         default: begin gain_v[0] = 1280; gain_v[1] = 1280; end
      endcase
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid low", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid low after reset", out_valid, 0);

      // R7: samples before any line start are discarded
      for (int i = 0; i < 40; i++) put(1'b0, i, 255 - i);
      check(out_valid == 1'b0, "R7 pre-line samples dropped", out_valid, 0);

      // Line 1: unity gain, samples at/below dark (R5), overclock 3
      setup_line(1);
      send_line(3, 0, 1'b1);
      drain(0, "L1");

      // R7: trailing samples after the line (beyond any overclock) are discarded
      for (int i = 0; i < 30; i++) put(1'b0, 200, 200);
      check(out_valid == 1'b0, "R7 trailing samples dropped", out_valid, 0);

      // Line 2: fractional and 1.5 gain, new dark levels (R4), gaps with junk (R10)
      setup_line(2);
      send_line(0, 3, 1'b0);
      begin
         logic [SW-1:0] held;
         held = out_data;
         repeat (3) @(negedge clk);
         check(out_valid == 1'b1 && out_data == held, "R8 hold while stalled", out_data, held);
      end
      drain(3, "L2");

      // Line 3: maximum gain clamps (R6), zero gain
      setup_line(3);
      send_line(5, 0, 1'b1);
      drain(2, "L3");

      // Line 4: full-scale dark level, 1.25 gain to clamp, longest overclock
      setup_line(4);
      send_line(23, 0, 1'b0);
      drain(0, "L4");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule